// File: doc/BRIEF.md
# Voice-Band CODEC Serial Frame Port

This block connects a parallel host audio path to a voice-band audio CODEC over a synchronous serial link. Each frame is one 16-bit word per direction. The word going to the CODEC carries a 13-bit two's-complement sample in its upper bits and a 3-bit volume code in its lower bits. The word coming back carries a 13-bit sample followed by three padding bits, which the port discards. At the nominal setting the frame rate is 8 ksps. The host drives the volume code to the no-attenuation value and sets loudness by scaling samples before it hands them over.

The port can be the timing master. In that mode it divides the system clock into a bit clock and emits a sync pulse one bit period wide at the start of every frame. It can also follow a bit clock and frame sync from outside, which it resynchronises to the system clock. The host sees one outbound holding register with a valid/ready handshake, and one inbound result register with a valid/ready handshake. If no new outbound sample is waiting when a frame starts, the previous sample is sent again and an underrun flag marks that frame.

Top module: `vbc_port`

## Requirements
- R1: The outbound word is {sample[12:0], volume[2:0]}, sent MSB first. Its MSB occupies the bit period right after the sync period, and its 16 bits fill 16 consecutive bit periods.
- R2: The first 13 bits of the inbound word are a two's-complement sample. rx_sample presents it sign-extended to 16 bits (rx_sample[15:13] copy bit 12), and the last 3 inbound bits have no effect on rx_sample.
- R3: In master mode (use_ext=0), bclk_o has a period of 2*HALF_DIV clocks, of which HALF_DIV clocks are high. fsync_o is high for exactly one bit period, and a frame lasts FRAME_BITS bit periods.
- R4: sdout changes only on the clock after a falling bit-clock event, and it is 0 outside the 16 data periods. sdin is sampled at rising bit-clock events.
- R5: tx_ready is 1 exactly when the holding register is empty. An accepted sample drops tx_ready, and the sample waits for the next frame start. tx_valid has no effect while tx_ready is 0.
- R6: A frame that starts with an empty holding register resends the last sent sample and sets tx_underrun. A frame that starts with a new sample clears tx_underrun. tx_underrun changes only at frame starts.
- R7: vol_code is captured at frame start. A change made after a frame has started first appears in the following frame.
- R8: rx_valid rises when a full inbound word is received. It stays high with rx_sample unchanged until rx_ready is seen, and a newer word replaces the older one.
- R9: With use_ext=1, ext_bclk and ext_fsync time the frames under the same bit layout, and bclk_o and fsync_o are held at 0.
- R10: During reset, sdout=0, tx_ready=1, tx_underrun=0 and rx_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_ext | input | 1 | 1 selects external bit clock and frame sync; held static |
| ext_bclk | input | 1 | External bit clock (follower mode) |
| ext_fsync | input | 1 | External frame sync (follower mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| fsync_o | output | 1 | Generated frame sync (master mode) |
| sdout | output | 1 | Serial data to the CODEC |
| sdin | input | 1 | Serial data from the CODEC |
| vol_code | input | 3 | Volume code placed in the low bits of each outbound word |
| tx_sample | input | 13 | Outbound sample from the host |
| tx_valid | input | 1 | Host offers tx_sample |
| tx_ready | output | 1 | Holding register empty |
| tx_underrun | output | 1 | Last frame repeated an old sample |
| rx_sample | output | 16 | Sign-extended inbound sample |
| rx_valid | output | 1 | rx_sample holds an unread word |
| rx_ready | input | 1 | Host takes rx_sample |

## Verification
The bench places sign-bit and pad-bit patterns in the serial words. A port that shifted the sample by a bit, or kept the pad bits, would show wrong low bits or a wrong sign-extension. It checks that a volume change made during a frame does not leak into that frame's word, which would happen if the code were read during shifting instead of at frame start. It withholds samples to force a repeat and then tries a second push while the holding register is full. A design that sent zeros, dropped the underrun flag or overwrote the held sample would fail these checks. The follower-mode test runs the same word checks under external timing, which exposes any misaligned edge detection.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  localparam int SMP_W  = 13;
  localparam int VOL_W  = 3;
  localparam int WORD_W = SMP_W + VOL_W;
  localparam int HOST_W = 16;
  localparam int LEFT_W = $clog2(WORD_W + 1);

  typedef logic [SMP_W-1:0]  smp_t;
  typedef logic [VOL_W-1:0]  vol_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HOST_W-1:0] host_t;

  typedef struct packed {
    logic fall;
    logic rise;
    logic sync;
  } bit_ev_t;

  // outbound slot: sample in the high bits, volume code in the low bits
  function automatic word_t pack_word(smp_t s, vol_t v);
    return {s, v};
  endfunction

  // inbound slot: keep the sample field, sign-extend, drop the pad bits
  function automatic host_t widen(word_t w);
    return {{(HOST_W-SMP_W){w[WORD_W-1]}}, w[WORD_W-1:VOL_W]};
  endfunction
endpackage

// File: rtl/vbc_timing.sv
module vbc_timing
  import vbc_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    use_ext,
  input  logic    ext_bclk,
  input  logic    ext_fsync,
  output logic    bclk_o,
  output logic    fsync_o,
  output bit_ev_t ev
);
  localparam int CNT_W = $clog2(2 * HALF_DIV);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * HALF_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF_DIV);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;
  logic             int_bclk, int_fsync, int_fall, int_rise;
  logic [2:0]       bsh;
  logic [1:0]       fsh;
  logic             ext_rise, ext_fall, ext_fs;

  // master divider: bit counter inside a frame counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      bitn <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt  <= '0;
      bitn <= (bitn == BIT_LAST) ? '0 : bitn + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign int_bclk  = (cnt >= CNT_HALF);
  assign int_fsync = (bitn == '0);
  assign int_fall  = (cnt == '0);
  assign int_rise  = (cnt == CNT_HALF);

  // follower: resynchronise the external clock and sync, find edges
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsh <= '0;
      fsh <= '0;
    end else begin
      bsh <= {bsh[1:0], ext_bclk};
      fsh <= {fsh[0], ext_fsync};
    end
  end

  assign ext_rise = bsh[1] & ~bsh[2];
  assign ext_fall = ~bsh[1] & bsh[2];
  assign ext_fs   = fsh[1];

  assign bclk_o  = use_ext ? 1'b0 : int_bclk;
  assign fsync_o = use_ext ? 1'b0 : int_fsync;

  always_comb begin
    ev.fall = use_ext ? ext_fall : int_fall;
    ev.rise = use_ext ? ext_rise : int_rise;
    ev.sync = ev.rise & (use_ext ? ext_fs : int_fsync);
  end
endmodule

// File: rtl/vbc_tx.sv
module vbc_tx
  import vbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  bit_ev_t ev,
  input  vol_t    vol_code,
  input  smp_t    tx_sample,
  input  logic    tx_valid,
  output logic    tx_ready,
  output logic    tx_underrun,
  output logic    sdout
);
  localparam logic [LEFT_W-1:0] WORD_CNT = LEFT_W'(WORD_W);

  smp_t              hold, last;
  logic              hold_full;
  word_t             shreg;
  logic [LEFT_W-1:0] left;
  logic              accept;

  assign accept   = tx_valid & ~hold_full;
  assign tx_ready = ~hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold        <= '0;
      last        <= '0;
      hold_full   <= 1'b0;
      shreg       <= '0;
      left        <= '0;
      sdout       <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      if (ev.sync) begin
        // frame boundary: choose new or repeated sample, capture volume
        shreg       <= pack_word(hold_full ? hold : last, vol_code);
        left        <= WORD_CNT;
        tx_underrun <= ~hold_full;
        if (hold_full) begin
          last      <= hold;
          hold_full <= 1'b0;
        end
      end else if (ev.fall) begin
        if (left != '0) begin
          sdout <= shreg[WORD_W-1];
          shreg <= {shreg[WORD_W-2:0], 1'b0};
          left  <= left - 1'b1;
        end else begin
          sdout <= 1'b0;
        end
      end
      if (accept) begin
        hold      <= tx_sample;
        hold_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vbc_rx.sv
module vbc_rx
  import vbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  bit_ev_t ev,
  input  logic    sdin,
  input  logic    rx_ready,
  output host_t   rx_sample,
  output logic    rx_valid,
  output logic    word_done
);
  localparam logic [LEFT_W-1:0] WORD_CNT = LEFT_W'(WORD_W);

  logic [SYNC_STAGES-1:0] sdin_sh;
  logic                   sdin_s;
  logic [WORD_W-2:0]      shreg;
  logic [LEFT_W-1:0]      left;

  always_ff @(posedge clk) begin
    if (!rst_n) sdin_sh <= '0;
    else        sdin_sh <= {sdin_sh[SYNC_STAGES-2:0], sdin};
  end
  assign sdin_s = sdin_sh[SYNC_STAGES-1];

  assign word_done = ev.rise & ~ev.sync & (left == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      left      <= '0;
      rx_sample <= '0;
      rx_valid  <= 1'b0;
    end else begin
      if (ev.sync) begin
        left <= WORD_CNT;
      end else if (ev.rise && left != '0) begin
        shreg <= {shreg[WORD_W-3:0], sdin_s};
        left  <= left - 1'b1;
      end
      if (rx_ready) rx_valid <= 1'b0;
      if (word_done) begin
        rx_sample <= widen({shreg, sdin_s});
        rx_valid  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vbc_port.sv
module vbc_port
  import vbc_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_ext,
  input  logic              ext_bclk,
  input  logic              ext_fsync,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic              sdout,
  input  logic              sdin,
  input  logic [VOL_W-1:0]  vol_code,
  input  logic [SMP_W-1:0]  tx_sample,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_underrun,
  output logic [HOST_W-1:0] rx_sample,
  output logic              rx_valid,
  input  logic              rx_ready
);
  bit_ev_t ev;
  logic    ev_fall, ev_rise, ev_sync;
  logic    word_done;

  vbc_timing #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_timing (
    .clk(clk), .rst_n(rst_n), .use_ext(use_ext),
    .ext_bclk(ext_bclk), .ext_fsync(ext_fsync),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .ev(ev)
  );

  // named event wires for the checker
  assign ev_fall = ev.fall;
  assign ev_rise = ev.rise;
  assign ev_sync = ev.sync;

  vbc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .ev(ev), .vol_code(vol_code),
    .tx_sample(tx_sample), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_underrun(tx_underrun), .sdout(sdout)
  );

  vbc_rx #(.SYNC_STAGES(2)) u_rx (
    .clk(clk), .rst_n(rst_n), .ev(ev), .sdin(sdin), .rx_ready(rx_ready),
    .rx_sample(rx_sample), .rx_valid(rx_valid), .word_done(word_done)
  );
endmodule

// File: rtl/vbc_checks.sv
module vbc_checks
  import vbc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              use_ext,
  input logic              bclk_o,
  input logic              fsync_o,
  input logic              sdout,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_underrun,
  input logic [HOST_W-1:0] rx_sample,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              ev_fall,
  input logic              ev_sync,
  input logic              word_done
);
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !word_done |=> rx_valid && $stable(rx_sample)); // R8
  AST_RX_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_sample[HOST_W-1:SMP_W-1] == {(HOST_W-SMP_W+1){rx_sample[SMP_W-1]}}); // R2
  AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(ev_fall)); // R4
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready); // R5
  AST_SYNC_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    !use_ext && ev_sync |-> fsync_o && bclk_o); // R3
  AST_UNDERRUN_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_underrun) |-> $past(ev_sync)); // R6
  AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext |-> !bclk_o && !fsync_o); // R9
endmodule

bind vbc_port vbc_checks u_checks (
  .clk(clk), .rst_n(rst_n), .use_ext(use_ext), .bclk_o(bclk_o),
  .fsync_o(fsync_o), .sdout(sdout), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_underrun(tx_underrun), .rx_sample(rx_sample), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .ev_fall(ev_fall), .ev_sync(ev_sync),
  .word_done(word_done)
);

// File: tb/vbc_port_test.sv
module vbc_port_test;
  localparam int HALF = 4;
  localparam int FB   = 20;
  localparam int EXT_H = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        use_ext = 0, ext_bclk = 0, ext_fsync = 0, ext_run = 0;
  logic        sdin = 0;
  logic [2:0]  vol_code = 3'd0;
  logic [12:0] tx_sample = '0;
  logic        tx_valid = 0, rx_ready = 0;
  logic        bclk_o, fsync_o, sdout, tx_ready, tx_underrun, rx_valid;
  logic [15:0] rx_sample;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vbc_port #(.HALF_DIV(HALF), .FRAME_BITS(FB)) uut (
    .clk(clk), .rst_n(rst_n), .use_ext(use_ext), .ext_bclk(ext_bclk),
    .ext_fsync(ext_fsync), .bclk_o(bclk_o), .fsync_o(fsync_o), .sdout(sdout),
    .sdin(sdin), .vol_code(vol_code), .tx_sample(tx_sample),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
    .rx_sample(rx_sample), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  // CODEC model on whichever clock and sync are in use
  wire mb = use_ext ? ext_bclk : bclk_o;
  wire mf = use_ext ? ext_fsync : fsync_o;
  int          frames = 0, cap_left = 0, drv_left = 0;
  logic [15:0] cap = '0, got_word = '0, codec_word = '0, drv = '0;

  always @(posedge mb) begin
    if (mf) begin
      cap_left = 16; drv = codec_word; drv_left = 16;
    end else if (cap_left > 0) begin
      cap = {cap[14:0], sdout};
      cap_left--;
      if (cap_left == 0) begin got_word = cap; frames++; end
    end
  end

  always @(negedge mb) begin
    if (drv_left > 0) begin sdin = drv[drv_left-1]; drv_left--; end
    else sdin = 0;
  end

  // external timing source
  always begin
    @(negedge clk);
    if (ext_run)
      for (int k = 0; k < FB; k++) begin
        ext_bclk = 0; ext_fsync = (k == 0);
        repeat (EXT_H) @(negedge clk);
        ext_bclk = 1;
        repeat (EXT_H) @(negedge clk);
      end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sext(logic [12:0] s);
    return {{3{s[12]}}, s};
  endfunction

  task automatic wait_sync();
    do @(posedge mb); while (!mf);
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_frames(int n);
    int t = frames + n;
    while (frames < t) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic push(logic [12:0] s);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_sample = s; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R10", sdout, 0, "sdout in reset");
    chk("R10", tx_ready, 1, "tx_ready in reset");
    chk("R10", tx_underrun, 0, "underrun in reset");
    chk("R10", rx_valid, 0, "rx_valid in reset");
  endtask

  task automatic t_timing();
    int n;
    while (fsync_o) @(negedge clk);
    while (!fsync_o) @(negedge clk);
    n = 0;
    while (fsync_o) begin n++; @(negedge clk); end
    while (!fsync_o) begin n++; @(negedge clk); end
    chk("R3", n, FB * 2 * HALF, "frame length in clocks");
    while (fsync_o) @(negedge clk);
    while (!fsync_o) @(negedge clk);
    n = 0;
    while (fsync_o) begin n++; @(negedge clk); end
    chk("R3", n, 2 * HALF, "fsync width in clocks");
    while (bclk_o) @(negedge clk);
    while (!bclk_o) @(negedge clk);
    n = 0;
    while (bclk_o) begin n++; @(negedge clk); end
    chk("R3", n, HALF, "bclk high time");
  endtask

  task automatic t_tx(logic [12:0] s, logic [2:0] v, string req);
    vol_code = v;
    wait_sync();
    push(s);
    wait_frames(2);
    chk(req, got_word, {s, v}, "outbound word");
    chk("R6", tx_underrun, 0, "underrun after fresh sample");
  endtask

  task automatic t_rx(logic [12:0] s, logic [2:0] pad);
    wait_sync();
    codec_word = {s, pad};
    wait_frames(2);
    chk("R2", rx_valid, 1, "rx_valid after word");
    chk("R2", rx_sample, sext(s), "sign-extended sample, pad ignored");
    rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask

  task automatic t_rx_hold();
    logic [15:0] first;
    wait_sync();
    codec_word = {13'h0A5A, 3'b010};
    wait_frames(2);
    first = rx_sample;
    repeat (10) @(negedge clk);
    chk("R8", rx_valid, 1, "valid held without ready");
    chk("R8", rx_sample, first, "sample held without ready");
    rx_ready = 1; @(negedge clk); rx_ready = 0; @(negedge clk);
    chk("R8", rx_valid, 0, "valid cleared by ready");
  endtask

  task automatic t_underrun();
    vol_code = 3'd5;
    wait_sync();
    push(13'h0123);
    wait_frames(2);
    chk("R6", got_word, {13'h0123, 3'd5}, "fresh sample sent");
    wait_frames(1);
    chk("R6", got_word, {13'h0123, 3'd5}, "old sample repeated");
    chk("R6", tx_underrun, 1, "underrun set on empty frame");
    push(13'h1456);
    wait_frames(1);
    chk("R6", got_word, {13'h1456, 3'd5}, "new sample after underrun");
    chk("R6", tx_underrun, 0, "underrun cleared");
  endtask

  task automatic t_ready();
    vol_code = 3'd1;
    wait_sync();
    push(13'h0C0C);
    @(negedge clk);
    chk("R5", tx_ready, 0, "ready low with full holding register");
    tx_sample = 13'h1DDD; tx_valid = 1;
    repeat (5) @(negedge clk);
    tx_valid = 0;
    wait_frames(2);
    chk("R5", got_word, {13'h0C0C, 3'd1}, "held sample sent");
    wait_frames(1);
    chk("R5", got_word, {13'h0C0C, 3'd1}, "push while not ready ignored");
  endtask

  task automatic t_volume();
    vol_code = 3'd5;
    wait_sync();
    vol_code = 3'd2;
    push(13'h0777);
    wait_frames(1);
    chk("R7", got_word[2:0], 3'd5, "mid-frame volume change not in current frame");
    wait_frames(1);
    chk("R7", got_word, {13'h0777, 3'd2}, "volume change in next frame");
  endtask

  task automatic t_ext();
    use_ext = 1; ext_run = 1;
    wait_sync();
    wait_frames(1);
    chk("R9", {bclk_o, fsync_o}, 2'b00, "master outputs quiet in follower mode");
    vol_code = 3'd3;
    codec_word = {13'h1A01, 3'b110};
    wait_sync();
    push(13'h1357);
    wait_frames(2);
    chk("R9", got_word, {13'h1357, 3'd3}, "outbound word under external timing");
    chk("R9", rx_sample, sext(13'h1A01), "inbound sample under external timing");
    chk("R9", rx_valid, 1, "rx_valid under external timing");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    @(negedge clk); rst_n = 1;
    t_timing();
    t_tx(13'h0ABC, 3'd5, "R1");
    t_tx(13'h1F01, 3'd4, "R1");
    t_rx(13'h1234, 3'b111);
    t_rx(13'h1800, 3'b000);
    t_rx(13'h0FFF, 3'b101);
    t_rx_hold();
    t_underrun();
    t_ready();
    t_volume();
    t_ext();
    finish_run();
  end
endmodule